// File: doc/BRIEF.md
# Configurable SPI Slave Shift Engine

This block is the serial half of an SPI peripheral working as a slave. An external master drives the serial clock, the active-low select and the serial data input. The engine returns one word per selected frame on its serial data output. Clock polarity, clock phase, bit order and word size (8 or 16 bits) are set at run time through configuration inputs. These inputs are held steady while the select line is high and left unchanged during a frame.

All serial inputs are brought into the system clock domain through two-flop synchronisers, and clock edges are found on the synchronised signal. For this reason the serial clock may run at no more than a quarter of the system clock. Each incoming bit is handled in two steps: it is first captured into a holding flop on one clock edge, then moved into the shift register on the opposite edge. Which edge does which depends on the phase setting.

When a whole word has arrived, it is copied into a received-data register and a full flag is raised. The flag stays up until the system side pulses a read strobe. The transmit word is taken from the system side at the moment the select line falls.

Top module: `spi_slave_engine`

## Requirements
- R1: After reset rx_full_o=0, rx_data_o=0 and sdo_oe_o=0. sdo_oe_o is 1 only while the synchronised select is low. When sdo_oe_o is 0, sdo_o is 0.
- R2: With cpha_i=0, the first outgoing bit appears on sdo_o within 4 system clocks after ss_ni falls, before any serial clock edge.
- R3: With cpha_i=1, each outgoing bit (the first included) is placed on sdo_o by an odd-numbered edge and holds until the next odd edge. The master samples it on the following even edge.
- R4: Edges are numbered from 1 in each frame. With cpha_i=0, odd edges capture sdi_i and even edges shift. With cpha_i=1, even edges capture sdi_i and odd edges shift. The word the master sends is received exactly.
- R5: cpol_i=1 inverts the serial clock before edges are numbered, so the idle level is high and the first edge is a falling edge.
- R6: lsb_first_i=0 sends and receives the most significant bit first. lsb_first_i=1 sends and receives bit 0 first. The same end of the register serves both directions.
- R7: wide_i=1 selects 16-bit words and wide_i=0 selects 8-bit words. For 8-bit words only tx_data_i[7:0] is sent, and rx_data_o[15:8] reads 0.
- R8: A frame completes on its 8th or 16th even-numbered edge. The received word is then copied into rx_data_o and rx_full_o is set. Otherwise rx_data_o holds its value.
- R9: rx_full_o stays set until a one-cycle pulse on rx_read_i clears it. A completion in the same cycle as the pulse keeps it set.
- R10: A word that completes while rx_full_o is set overwrites rx_data_o.
- R11: If ss_ni rises part way through a word, the word is dropped: rx_full_o and rx_data_o do not change, and the next frame starts again from edge 1.
- R12: tx_data_i is loaded into the shift register on the synchronised falling edge of ss_ni. Changes to tx_data_i later in the frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master |
| ss_ni | input | 1 | Slave select, active low |
| sdi_i | input | 1 | Serial data from the master |
| sdo_o | output | 1 | Serial data to the master |
| sdo_oe_o | output | 1 | Output enable for sdo_o (pad is tri-stated when 0) |
| cpol_i | input | 1 | Clock polarity, 1 = idle high |
| cpha_i | input | 1 | Clock phase select |
| lsb_first_i | input | 1 | 1 = least significant bit first |
| wide_i | input | 1 | 1 = 16-bit word, 0 = 8-bit word |
| tx_data_i | input | 16 | Word to send in the next frame |
| rx_data_o | output | 16 | Last word received in full |
| rx_full_o | output | 1 | Received word waiting to be read |
| rx_read_i | input | 1 | Read strobe that clears rx_full_o |

## Verification
A wrong edge count or a wrong completion compare shows up the first time a frame ends. rx_full_o rises too early or too late against the last even edge, or rx_data_o holds a word that is shifted by one or more bits.

A wrong capture/shift assignment, or a wrong output register choice in phase 1, shows at once on sdo_o. The master then reads a word that is rotated by one bit in the first frame of that mode. A bit-order or word-size fault mirrors or truncates the word in both directions in the same frame.

A stale counter after an aborted frame shows up only in the frame that follows. That frame completes early, so the bench runs a full frame right after each abort.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb_first;
    logic wide;
  } spi_cfg_t;
endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_eng_edge.sv
module spi_eng_edge
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8,
  localparam int unsigned CNT_W   = $clog2(DATA_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_s_i,
  input  logic             cs_s_ni,
  input  spi_cfg_t         cfg_i,
  output logic             cs_fall_o,
  output logic             latch_o,
  output logic             shift_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             k, k_q, cs_q, sel;
  logic             lead, trail;
  logic [CNT_W-1:0] cnt_q, last;

  // polarity folded in: rising of k is always an odd edge
  assign k     = sck_s_i ^ cfg_i.cpol;
  assign sel   = !cs_s_ni;
  assign lead  = sel & k & !k_q;
  assign trail = sel & !k & k_q;
  assign last  = cfg_i.wide ? CNT_W'(DATA_W-1) : CNT_W'(NARROW_W-1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q  <= 1'b0;
      cs_q <= 1'b1;
    end else begin
      k_q  <= k;
      cs_q <= cs_s_ni;
    end
  end

  // counts even edges; Nth even edge ends the word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!sel) cnt_q <= '0;
    else if (trail) cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  assign cs_fall_o = sel & cs_q;
  assign latch_o   = cfg_i.cpha ? trail : lead;
  assign shift_o   = cfg_i.cpha ? lead : trail;
  assign done_o    = trail && (cnt_q == last);
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  spi_cfg_t          cfg_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              latch_i,
  input  logic              shift_i,
  input  logic              sdi_s_i,
  output logic              sdo_bit_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] sh_q;
  logic              lat_q, out_q;
  logic              in_bit;

  function automatic logic [DATA_W-1:0] narrow_mask(input logic [DATA_W-1:0] w, input logic wide);
    logic [DATA_W-1:0] v;
    v = w;
    if (!wide) v[DATA_W-1:NARROW_W] = '0;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] r, input logic b,
                                             input spi_cfg_t c);
    logic [DATA_W-1:0] v;
    if (!c.lsb_first) begin
      v = {r[DATA_W-2:0], b};
    end else if (c.wide) begin
      v = {b, r[DATA_W-1:1]};
    end else begin
      v = '0;
      v[NARROW_W-2:0] = r[NARROW_W-1:1];
      v[NARROW_W-1]   = b;
    end
    return narrow_mask(v, c.wide);
  endfunction

  function automatic logic out_end(input logic [DATA_W-1:0] r, input spi_cfg_t c);
    if (c.lsb_first) return r[0];
    return c.wide ? r[DATA_W-1] : r[NARROW_W-1];
  endfunction

  // phase 1 finishes on its last capture edge: take sdi directly
  assign in_bit = cfg_i.cpha ? sdi_s_i : lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      lat_q <= 1'b0;
      out_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= narrow_mask(tx_i, cfg_i.wide);
      out_q <= 1'b0;
    end else begin
      if (latch_i) lat_q <= sdi_s_i;
      if (shift_i) begin
        sh_q <= step(sh_q, lat_q, cfg_i);
        if (cfg_i.cpha) out_q <= out_end(sh_q, cfg_i);
      end
    end
  end

  assign sdo_bit_o = cfg_i.cpha ? out_q : out_end(sh_q, cfg_i);
  assign rx_word_o = step(sh_q, in_bit, cfg_i);
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_eng_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_first_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  input  logic              rx_read_i
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  spi_cfg_t          cfg;
  logic              sck_s, cs_s_n, sdi_s;
  logic              cs_fall, latch, shift, done;
  logic [CNT_W-1:0]  bit_cnt;
  logic              sdo_bit;
  logic [DATA_W-1:0] rx_word, rx_q;
  logic              full_q;

  assign cfg = '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i, wide: wide_i};

  spi_eng_sync #(.WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ss_ni, sdi_i}),
    .q_o   ({sck_s, cs_s_n, sdi_s})
  );

  spi_eng_edge #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_s_i  (sck_s),
    .cs_s_ni  (cs_s_n),
    .cfg_i    (cfg),
    .cs_fall_o(cs_fall),
    .latch_o  (latch),
    .shift_o  (shift),
    .done_o   (done),
    .cnt_o    (bit_cnt)
  );

  spi_eng_shift #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (cfg),
    .load_i   (cs_fall),
    .tx_i     (tx_data_i),
    .latch_i  (latch),
    .shift_i  (shift),
    .sdi_s_i  (sdi_s),
    .sdo_bit_o(sdo_bit),
    .rx_word_o(rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (done) rx_q <= rx_word;
      if (done) full_q <= 1'b1;
      else if (rx_read_i) full_q <= 1'b0;
    end
  end

  assign sdo_oe_o  = !cs_s_n;
  assign sdo_o     = sdo_oe_o & sdo_bit;
  assign rx_data_o = rx_q;
  assign rx_full_o = full_q;
endmodule

// File: rtl/spi_slave_engine_chk.sv
module spi_slave_engine_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ss_ni,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_full_o,
  input logic              rx_read_i,
  input logic              cs_s_n,
  input logic              done,
  input logic [CNT_W-1:0]  bit_cnt
);
  p_oe_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_ni && $past(ss_ni) && $past(ss_ni, 2) && $past(ss_ni, 3)) |-> (!sdo_oe_o && !sdo_o));

  p_done_sets_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full_o);

  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(rx_data_o));

  p_read_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_read_i && !done) |=> !rx_full_o);

  p_full_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rx_read_i) |=> rx_full_o);

  p_abort_clears_cnt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_n |=> (bit_cnt == '0));

  p_no_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s_n |-> !done);
endmodule

bind spi_slave_engine spi_slave_engine_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ss_ni    (ss_ni),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o),
  .rx_data_o(rx_data_o),
  .rx_full_o(rx_full_o),
  .rx_read_i(rx_read_i),
  .cs_s_n   (cs_s_n),
  .done     (done),
  .bit_cnt  (bit_cnt)
);

// File: tb/spi_slave_engine_tb_top.sv
module spi_slave_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 8;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0, ss_ni = 1'b1, sdi_i = 1'b0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0, wide_i = 1'b0;
  logic [15:0] tx_data_i = '0;
  logic        rx_read_i = 1'b0;
  logic        sdo_o, sdo_oe_o, rx_full_o;
  logic [15:0] rx_data_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_slave_engine dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .ss_ni(ss_ni), .sdi_i(sdi_i),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .cpol_i(cpol_i), .cpha_i(cpha_i),
    .lsb_first_i(lsb_first_i), .wide_i(wide_i), .tx_data_i(tx_data_i),
    .rx_data_o(rx_data_o), .rx_full_o(rx_full_o), .rx_read_i(rx_read_i)
  );

  function automatic logic [15:0] msk(input logic [15:0] w, input bit wide);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  // bit sent in serial slot i
  function automatic logic ser_bit(input logic [15:0] w, input int i, input bit lsb, input bit wide);
    int n = wide ? 16 : 8;
    return lsb ? w[i] : w[n-1-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_cfg(input bit pol, input bit pha, input bit lsb, input bit wide);
    cpol_i = pol; cpha_i = pha; lsb_first_i = lsb; wide_i = wide;
    sck_i = pol;
    clk_n(6);
  endtask

  task automatic read_rx();
    rx_read_i = 1'b1;
    clk_n(1);
    rx_read_i = 1'b0;
    clk_n(1);
  endtask

  // drives nbits serial slots; returns bits seen on sdo
  task automatic xfer(input logic [15:0] tx, input logic [15:0] mosi, input int nbits,
                      input bit check_first, output logic [15:0] miso);
    bit pha = cpha_i, lsb = lsb_first_i, wide = wide_i, pol = cpol_i;
    int n = wide ? 16 : 8;
    miso = '0;
    tx_data_i = tx;
    if (!pha) sdi_i = ser_bit(mosi, 0, lsb, wide);
    ss_ni = 1'b0;
    clk_n(6);
    tx_data_i = ~tx; // R12: later change must not reach the frame
    if (check_first && !pha) begin
      chk("R2 first bit before edge", sdo_o, ser_bit(msk(tx, wide), 0, lsb, wide));
      chk("R1 oe when selected", sdo_oe_o, 1);
    end
    for (int i = 0; i < nbits; i++) begin
      if (!pha) begin
        clk_n(HALF_SCK);
        if (lsb) miso[i] = sdo_o; else miso[n-1-i] = sdo_o;
        sck_i = !pol;
        clk_n(HALF_SCK);
        sck_i = pol;
        if (i + 1 < n) sdi_i = ser_bit(mosi, i + 1, lsb, wide);
      end else begin
        clk_n(HALF_SCK);
        sck_i = !pol;
        sdi_i = ser_bit(mosi, i, lsb, wide);
        clk_n(HALF_SCK);
        if (lsb) miso[i] = sdo_o; else miso[n-1-i] = sdo_o;
        sck_i = pol;
      end
    end
    clk_n(HALF_SCK);
    ss_ni = 1'b1;
    clk_n(6);
  endtask

  task automatic full_frame(input string tag, input logic [15:0] tx, input logic [15:0] mosi,
                            input bit do_read);
    logic [15:0] miso;
    bit wide = wide_i;
    xfer(tx, mosi, wide ? 16 : 8, 1'b1, miso);
    chk({tag, " R4/R6 miso word"}, miso, msk(tx, wide));
    chk({tag, " R8 rx_data"}, rx_data_o, msk(mosi, wide));
    chk({tag, " R8 rx_full set"}, rx_full_o, 1);
    chk({tag, " R1 oe idle"}, {sdo_oe_o, sdo_o}, 0);
    if (do_read) begin
      read_rx();
      chk({tag, " R9 cleared by read"}, rx_full_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    clk_n(3);
    chk("R1 reset full", rx_full_o, 0);
    chk("R1 reset data", rx_data_o, 0);
    chk("R1 reset oe", sdo_oe_o, 0);
    rst_ni = 1'b1;
    clk_n(4);

    // directed: mode 0, msb first, 8-bit
    set_cfg(0, 0, 0, 0);
    full_frame("dir0", 16'h12A5, 16'hFF3C, 1'b0);
    chk("R7 upper zero", rx_data_o[15:8], 0);
    clk_n(40);
    chk("R9 flag held", rx_full_o, 1);
    read_rx();
    chk("R9 read clears", rx_full_o, 0);

    // every configuration (R3 R5 R6 R7)
    for (int c = 0; c < 16; c++) begin
      set_cfg(c[3], c[2], c[1], c[0]);
      full_frame($sformatf("cfg%0d R3 R5", c), 16'($urandom), 16'($urandom), 1'b1);
    end

    // R10 overwrite
    set_cfg(1, 1, 0, 1);
    full_frame("ovw1", 16'h0F0F, 16'hBEEF, 1'b0);
    full_frame("ovw2 R10", 16'hF0F0, 16'h1357, 1'b0);
    chk("R10 overwrite data", rx_data_o, 16'h1357);
    read_rx();

    // R11 abort mid word then clean frame
    for (int a = 0; a < 4; a++) begin
      logic [15:0] miso;
      logic [15:0] prev;
      set_cfg(a[0], a[1], 0, 1);
      prev = rx_data_o;
      xfer(16'hAAAA, 16'h5555, 5 + a, 1'b0, miso);
      chk("R11 abort no flag", rx_full_o, 0);
      chk("R11 abort data kept", rx_data_o, prev);
      full_frame("post-abort R11", 16'hC3A1, 16'h7E81, 1'b1);
    end

    // constrained random
    for (int r = 0; r < 40; r++) begin
      set_cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      full_frame("rand", 16'($urandom), 16'($urandom), 1'b1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule